// File: doc/BRIEF.md
# Rotating Register Rename Unit

This block maps a logical register number to a physical register number for software-pipelined loops. Three register classes each own a rotating window: general, floating-point and predicate registers. Every loop iteration the surrounding control pulses a rotate input. That pulse advances a per-window offset, so a name the loop body reuses refers to a fresh physical register on the next pass. The predicate window rotates with the others, which steps each iteration's guard predicate through the prolog, kernel and epilog stages of the loop.

The lookup is purely combinational: class and logical index go in, and the physical index comes out in the same cycle. Only the three offsets and the programmable general-window size are stored. Numbers below a window's base, or above its top, pass through unchanged. The general window starts at 32, and software loads its size. The floating-point window (32 to 127) and the predicate window (16 to 63) have fixed sizes. The block has no state machine; its only sequential state is the rotation counters.

Top module: `rot_rename`

## Requirements
- R1: For class code 0 (general), logical indices 0 to 31 come out unchanged.
- R2: For class code 0, an index L in 32 to 32+S-1, where S is the current general size, maps to 32 + ((L-32+G) mod S), with G the general offset. Indices from 32+S upward pass through.
- R3: For class code 1 (floating-point), indices 0 to 31 pass through. Indices 32 to 127 map to 32 + ((L-32+F) mod 96), with F the floating-point offset.
- R4: For class code 2 (predicate), indices 0 to 15 pass through. Indices 16 to 63 map to 16 + ((L-16+P) mod 48), with P the predicate offset. Indices 64 to 127 pass through.
- R5: Each cycle with rot_i high at the clock edge advances G, F and P by one. Each offset wraps to 0 when it reaches its window size. After one rotate, general 32 maps to 33.
- R6: A clock edge with size_ld_i high sets the general size to size_i, clamped to a maximum of 96, and clears G to 0. If rot_i is high in the same cycle, G is still cleared, while F and P advance.
- R7: After reset all offsets are 0 and the general size is 96, so every index maps to itself.
- R8: With a general size of 0, every general index passes through and rotates leave the general mapping unchanged.
- R9: Class code 3 passes every index through unchanged.
- R10: The output follows class and index within the same cycle. A rotate changes the mapping only after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rot_i | input | 1 | Rotate pulse, one per loop iteration |
| size_ld_i | input | 1 | Load a new general window size |
| size_i | input | 8 | General window size to load |
| cls_i | input | 2 | Register class: 0 general, 1 floating-point, 2 predicate, 3 pass |
| lidx_i | input | 7 | Logical register index |
| pidx_o | output | 7 | Physical register index |

## Verification
The mapping is swept over all 128 indices of every class at several offsets:
- At zero offsets the sweep separates a missing pass-through from a real rotation.
- After a single rotate it exposes an offset applied in the wrong direction.
- At 48 and 96 rotations it checks that each window's wrap happens at its own size and not at another's.

The general window is then reloaded:
- A small size shows that the top of the window moves and the offset clears.
- An oversized value exercises the clamp.
- A size of zero shows the general window switched off.

A load issued together with a rotate shows that the clear takes priority only for the general window. A check taken between raising the rotate pulse and the clock edge tells a registered offset apart from a combinational one.

// File: rtl/rr_pkg.sv
package rr_pkg;
    typedef enum logic [1:0] {
        CLS_GEN = 2'd0,
        CLS_FLT = 2'd1,
        CLS_PRD = 2'd2,
        CLS_RAW = 2'd3
    } reg_cls_e;

    localparam int NWIN = 3;
endpackage

// File: rtl/rr_offset.sv
module rr_offset #(
    parameter int SZ_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv_i,
    input  logic            clr_i,
    input  logic [SZ_W-1:0] size_i,
    output logic [SZ_W-1:0] off_o
);
    logic [SZ_W-1:0] off_q;
    logic [SZ_W-1:0] off_inc;

    always_comb begin
        off_inc = off_q + SZ_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q <= '0;
        end else if (clr_i) begin
            off_q <= '0;
        end else if (adv_i) begin
            if (off_inc >= size_i) off_q <= '0;
            else                   off_q <= off_inc;
        end
    end

    assign off_o = off_q;

    // R6
    offset_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (off_o == '0));

    // R5
    offset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !clr_i) |=> $stable(off_o));

    // R5
    offset_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (off_o < size_i) || (off_o == '0));
endmodule

// File: rtl/rr_map.sv
module rr_map #(
    parameter int IDX_W = 7,
    parameter int SZ_W  = 8,
    parameter int BASE  = 32
) (
    input  logic [IDX_W-1:0] lidx_i,
    input  logic [SZ_W-1:0]  size_i,
    input  logic [SZ_W-1:0]  off_i,
    output logic [IDX_W-1:0] pidx_o
);
    localparam logic [SZ_W:0] BASE_V = (SZ_W+1)'(BASE);

    logic [SZ_W:0] lext;
    logic [SZ_W:0] rel;
    logic [SZ_W:0] sum;
    logic [SZ_W:0] wrapped;
    logic [SZ_W:0] phys;
    logic          in_rgn;

    always_comb begin
        lext    = (SZ_W+1)'(lidx_i);
        rel     = lext - BASE_V;
        in_rgn  = (lext >= BASE_V) && (rel < {1'b0, size_i});
        sum     = rel + {1'b0, off_i};
        wrapped = (sum >= {1'b0, size_i}) ? (sum - {1'b0, size_i}) : sum;
        phys    = wrapped + BASE_V;
        pidx_o  = in_rgn ? phys[IDX_W-1:0] : lidx_i;
    end
endmodule

// File: rtl/rot_rename.sv
module rot_rename #(
    parameter int NREG    = 128,
    parameter int GR_BASE = 32,
    parameter int FR_BASE = 32,
    parameter int PR_BASE = 16,
    parameter int PR_NUM  = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rot_i,
    input  logic       size_ld_i,
    input  logic [7:0] size_i,
    input  logic [1:0] cls_i,
    input  logic [6:0] lidx_i,
    output logic [6:0] pidx_o
);
    import rr_pkg::*;

    localparam int IDX_W   = $clog2(NREG);
    localparam int SZ_W    = IDX_W + 1;
    localparam int GR_MAX  = NREG - GR_BASE;
    localparam int FR_SIZE = NREG - FR_BASE;
    localparam int PR_SIZE = PR_NUM - PR_BASE;
    localparam int WIN_BASE [NWIN] = '{GR_BASE, FR_BASE, PR_BASE};

    logic [SZ_W-1:0]  gsize_q;
    logic [SZ_W-1:0]  win_size [NWIN];
    logic             win_clr  [NWIN];
    logic [SZ_W-1:0]  win_off  [NWIN];
    logic [IDX_W-1:0] win_pidx [NWIN];
    reg_cls_e         cls;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gsize_q <= SZ_W'(GR_MAX);
        end else if (size_ld_i) begin
            if (size_i > SZ_W'(GR_MAX)) gsize_q <= SZ_W'(GR_MAX);
            else                        gsize_q <= size_i;
        end
    end

    always_comb begin
        win_size[0] = gsize_q;
        win_size[1] = SZ_W'(FR_SIZE);
        win_size[2] = SZ_W'(PR_SIZE);
        win_clr[0]  = size_ld_i;
        win_clr[1]  = 1'b0;
        win_clr[2]  = 1'b0;
    end

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        rr_offset #(.SZ_W(SZ_W)) u_off (
            .clk    (clk),
            .rst_n  (rst_n),
            .adv_i  (rot_i),
            .clr_i  (win_clr[g]),
            .size_i (win_size[g]),
            .off_o  (win_off[g])
        );
        rr_map #(.IDX_W(IDX_W), .SZ_W(SZ_W), .BASE(WIN_BASE[g])) u_map (
            .lidx_i (lidx_i),
            .size_i (win_size[g]),
            .off_i  (win_off[g]),
            .pidx_o (win_pidx[g])
        );
    end

    always_comb begin
        cls = reg_cls_e'(cls_i);
        unique case (cls)
            CLS_GEN: pidx_o = win_pidx[0];
            CLS_FLT: pidx_o = win_pidx[1];
            CLS_PRD: pidx_o = win_pidx[2];
            default: pidx_o = lidx_i;
        endcase
    end

    // R1
    gen_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_i == 2'd0 && lidx_i < IDX_W'(GR_BASE)) |-> (pidx_o == lidx_i));

    // R3
    flt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_i == 2'd1 && lidx_i >= IDX_W'(FR_BASE)) |-> (pidx_o >= IDX_W'(FR_BASE)));

    // R4
    prd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_i == 2'd2 && lidx_i >= IDX_W'(PR_BASE) && lidx_i < IDX_W'(PR_NUM))
        |-> (pidx_o >= IDX_W'(PR_BASE) && pidx_o < IDX_W'(PR_NUM)));

    // R9
    raw_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_i == 2'd3) |-> (pidx_o == lidx_i));

    // R6
    size_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gsize_q <= SZ_W'(GR_MAX));
endmodule

// File: tb/rot_rename_tb.sv
module rot_rename_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rot_i = 1'b0;
    logic       size_ld_i = 1'b0;
    logic [7:0] size_i = '0;
    logic [1:0] cls_i = '0;
    logic [6:0] lidx_i = '0;
    logic [6:0] pidx_o;

    int checks = 0;
    int errors = 0;
    int go = 0, fo = 0, po = 0, gs = 96;
    bit done = 0;

    rot_rename u_dut (
        .clk(clk), .rst_n(rst_n), .rot_i(rot_i), .size_ld_i(size_ld_i),
        .size_i(size_i), .cls_i(cls_i), .lidx_i(lidx_i), .pidx_o(pidx_o)
    );

    always #5 clk = ~clk;

    function automatic int rot_fn(int l, int b, int s, int o);
        if (l >= b && (l - b) < s) return b + ((l - b + o) % s);
        return l;
    endfunction

    function automatic int exp_map(int c, int l);
        case (c)
            0: return rot_fn(l, 32, gs, go);
            1: return rot_fn(l, 32, 96, fo);
            2: return rot_fn(l, 16, 48, po);
            default: return l;
        endcase
    endfunction

    task automatic chk(string req, int c, int l, int exp);
        cls_i = 2'(c);
        lidx_i = 7'(l);
        #1;
        checks++;
        if (int'(pidx_o) != exp) begin
            errors++;
            $display("FAIL %s cls=%0d idx=%0d got %0d exp %0d", req, c, l, pidx_o, exp);
        end
    endtask

    task automatic sweep(string req, int c);
        for (int l = 0; l < 128; l++) chk(req, c, l, exp_map(c, l));
    endtask

    function automatic void model_rot(bit clr_g);
        if (clr_g) go = 0;
        else go = (gs == 0) ? 0 : (go + 1) % gs;
        fo = (fo + 1) % 96;
        po = (po + 1) % 48;
    endfunction

    task automatic do_rotate(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rot_i = 1'b1;
            @(negedge clk);
            rot_i = 1'b0;
            model_rot(1'b0);
        end
    endtask

    task automatic do_load(int v, bit with_rot);
        @(negedge clk);
        size_i = 8'(v);
        size_ld_i = 1'b1;
        rot_i = with_rot;
        @(negedge clk);
        size_ld_i = 1'b0;
        rot_i = 1'b0;
        gs = (v > 96) ? 96 : v;
        if (with_rot) model_rot(1'b1);
        else go = 0;
    endtask

    task automatic t_reset;
        for (int c = 0; c < 4; c++)
            for (int l = 0; l < 128; l++) chk("R7", c, l, l);
        chk("R1", 0, 31, 31);
        chk("R9", 3, 100, 100);
    endtask

    task automatic t_one_rotate;
        // R10: the pulse is raised but not yet sampled
        @(negedge clk);
        rot_i = 1'b1;
        chk("R10", 0, 32, 32);
        @(negedge clk);
        rot_i = 1'b0;
        model_rot(1'b0);
        chk("R5", 0, 32, 33);
        chk("R3", 1, 127, 32);
        chk("R4", 2, 63, 16);
        chk("R4", 2, 15, 15);
        chk("R4", 2, 64, 64);
        sweep("R2", 0);
        sweep("R3", 1);
        sweep("R4", 2);
        sweep("R9", 3);
    endtask

    task automatic t_wrap;
        do_rotate(47);
        chk("R5", 2, 16, 16);
        chk("R5", 1, 32, 80);
        do_rotate(48);
        chk("R5", 0, 32, 32);
        chk("R5", 1, 100, 100);
        sweep("R5", 0);
        sweep("R5", 1);
        sweep("R5", 2);
    endtask

    task automatic t_load_small;
        do_rotate(3);
        do_load(10, 1'b0);
        chk("R6", 0, 32, 32);
        chk("R6", 0, 41, 41);
        do_rotate(3);
        chk("R2", 0, 32, 35);
        chk("R2", 0, 41, 34);
        chk("R2", 0, 42, 42);
        chk("R1", 0, 5, 5);
        sweep("R2", 0);
    endtask

    task automatic t_clamp;
        do_load(120, 1'b0);
        do_rotate(1);
        chk("R6", 0, 127, 32);
        sweep("R6", 0);
    endtask

    task automatic t_simul;
        do_rotate(5);
        do_load(20, 1'b1);
        chk("R6", 0, 40, 40);
        chk("R6", 0, 52, 52);
        sweep("R6", 1);
        sweep("R6", 2);
        sweep("R6", 0);
    endtask

    task automatic t_zero;
        do_load(0, 1'b0);
        do_rotate(2);
        chk("R8", 0, 40, 40);
        chk("R8", 0, 127, 127);
        sweep("R8", 0);
        sweep("R3", 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_one_rotate();
        t_wrap();
        t_load_small();
        t_clamp();
        t_simul();
        t_zero();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule